// File: doc/BRIEF.md
# Reduced-Precision Systolic Matrix Multiplier

This block computes the matrix product C = A × B on a square array of N×N multiply-accumulate cells. Operands are 16-bit brain-float values: 1 sign bit, an 8-bit exponent and a 7-bit fraction. Each product is formed exactly as an IEEE single-precision value. Each cell keeps its own 32-bit single-precision running sum, and no step narrows it. Operands reach only the left and top edges of the array. From there they hop one cell per clock, so no interior cell sees a port.

On each beat the user drives one column of A, where lane i carries A[i][k], and one row of B, where lane j carries B[k][j], and raises `in_vld_i`. Lane i of A and lane j of B are delayed by i and j cycles inside the block, so that A[i][k] and B[k][j] meet in cell (i,j). A clear pulse zeroes every accumulator before a new tile. A drain request then shifts the accumulators up the array. Row 0 comes out first, one row per cycle, tagged by `out_vld_o`.

Top module: `mm_systolic`

## Requirements
- R1: A product of two normal bf16 inputs equals the exact real product written as fp32. No rounding is applied to it; the fraction is widened by appending zero bits.
- R2: Each accumulation is an fp32 addition rounded to nearest, ties to even. For every cell, products are added in the order of the beats.
- R3: When the last operand beat is in cycle L, a drain request driven in cycle L+2N-1 returns the complete result for every cell. For a dense tile of K beats this is cycle 2N+K-2 after the first beat.
- R4: `clr_i` zeroes every accumulator. If it is high in the same cycle as the first beat of a tile, that tile starts from zero and includes its first product.
- R5: A cell's accumulator holds its value in every cycle in which no valid operand pair reaches it. Gaps in `in_vld_i` and a tile issued without `clr_i` therefore continue the running sums.
- R6: `drain_i` starts a drain in the next cycle. `out_vld_o` is then high for exactly N cycles, and `out_row_o` carries rows 0 to N-1 in order, with lane j at bits [32j+31:32j]. After the drain every accumulator is +0.
- R7: A `drain_i` pulse while a drain is in progress is ignored; it neither restarts nor lengthens the drain.
- R8: A NaN input, or infinity multiplied by zero, gives the quiet NaN 0x7FC00000. Infinity plus infinity of opposite sign also gives 0x7FC00000, and a NaN accumulator stays NaN.
- R9: A product or sum whose exponent exceeds 254 saturates to infinity with the correct sign. Inputs with a zero exponent field (denormals) count as +0. Results below the normal range flush to +0, and exact cancellation gives +0.
- R10: After reset `out_vld_o` is low and `out_row_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Zero all accumulators |
| in_vld_i | input | 1 | Operand beat valid |
| a_col_i | input | 16·N | Lane i: bf16 element A[i][k] |
| b_row_i | input | 16·N | Lane j: bf16 element B[k][j] |
| drain_i | input | 1 | Request to shift results out |
| out_vld_o | output | 1 | Result row valid |
| out_row_o | output | 32·N | Lane j: fp32 element C[r][j] of the current row r |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is clearing and accumulating: the bench raises `clr_i` together with the first beat of a tile that lands on stale sums, and the drained rows must hold only the new tile's products. The second pair is a running drain and a fresh drain request: the bench holds `drain_i` high across the first drain cycles. The out-valid flag is compared every clock, and it must stay high for exactly N cycles with rows in order. The expected values come from a model that adds exact double-precision sums and rounds them to single precision after every step.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int BF_W = 16;
  localparam int FP_W = 32;
  localparam logic [FP_W-1:0] F32_QNAN = 32'h7fc0_0000;

  // bf16 x bf16 -> exact fp32; denormals read as zero
  function automatic logic [FP_W-1:0] bf_mul(input logic [BF_W-1:0] a, input logic [BF_W-1:0] b);
    logic s, az, bz, an, bn, ai, bi;
    logic [15:0] p;
    logic [22:0] f;
    int e;
    s  = a[15] ^ b[15];
    az = a[14:7] == 8'h00;
    bz = b[14:7] == 8'h00;
    an = (a[14:7] == 8'hff) && (a[6:0] != 7'd0);
    bn = (b[14:7] == 8'hff) && (b[6:0] != 7'd0);
    ai = (a[14:7] == 8'hff) && (a[6:0] == 7'd0);
    bi = (b[14:7] == 8'hff) && (b[6:0] == 7'd0);
    if (an || bn || (ai && bz) || (bi && az)) return F32_QNAN;
    if (ai || bi) return {s, 8'hff, 23'd0};
    if (az || bz) return '0;
    p = {1'b1, a[6:0]} * {1'b1, b[6:0]};
    e = int'(a[14:7]) + int'(b[14:7]) - 127;
    if (p[15]) begin
      f = {p[14:0], 8'd0};
      e = e + 1;
    end else begin
      f = {p[13:0], 9'd0};
    end
    if (e >= 255) return {s, 8'hff, 23'd0};
    if (e <= 0) return '0;
    return {s, 8'(e), f};
  endfunction

  // fp32 add, round to nearest even, flush-to-zero
  function automatic logic [FP_W-1:0] f32_add(input logic [FP_W-1:0] x, input logic [FP_W-1:0] y);
    logic xz, yz, xn, yn, xi, yi, swap, bs, ss;
    logic [7:0] be, se;
    logic [26:0] bm, sm, al;
    logic [27:0] sum;
    logic [24:0] rm;
    logic [22:0] mant;
    int d, e, sh, p;
    xz = x[30:23] == 8'h00;
    yz = y[30:23] == 8'h00;
    xn = (x[30:23] == 8'hff) && (x[22:0] != 23'd0);
    yn = (y[30:23] == 8'hff) && (y[22:0] != 23'd0);
    xi = (x[30:23] == 8'hff) && (x[22:0] == 23'd0);
    yi = (y[30:23] == 8'hff) && (y[22:0] == 23'd0);
    if (xn || yn || (xi && yi && (x[31] != y[31]))) return F32_QNAN;
    if (xi) return x;
    if (yi) return y;
    if (xz && yz) return '0;
    if (xz) return y;
    if (yz) return x;
    swap = y[30:0] > x[30:0];
    bs = swap ? y[31] : x[31];
    ss = swap ? x[31] : y[31];
    be = swap ? y[30:23] : x[30:23];
    se = swap ? x[30:23] : y[30:23];
    bm = {1'b1, (swap ? y[22:0] : x[22:0]), 3'b000};
    sm = {1'b1, (swap ? x[22:0] : y[22:0]), 3'b000};
    d  = int'(be) - int'(se);
    if (d > 26) begin
      al = 27'd1;
    end else begin
      al = sm >> d;
      if ((sm << (27 - d)) != 27'd0) al[0] = 1'b1;
    end
    if (bs == ss) begin
      sum = {1'b0, bm} + {1'b0, al};
      e = int'(be);
      if (sum[27]) begin
        sum = {1'b0, sum[27:2], sum[1] | sum[0]};
        e = e + 1;
      end
    end else begin
      sum = {1'b0, bm} - {1'b0, al};
      if (sum == 28'd0) return '0;
      p = 0;
      for (int i = 0; i < 27; i++) if (sum[i]) p = i;
      sh  = 26 - p;
      sum = sum << sh;
      e   = int'(be) - sh;
    end
    rm = {1'b0, sum[26:3]} + 25'(sum[2] & (sum[1] | sum[0] | sum[3]));
    mant = rm[22:0];
    if (rm[24]) begin
      mant = 23'd0;
      e = e + 1;
    end
    if (e >= 255) return {bs, 8'hff, 23'd0};
    if (e <= 0) return '0;
    return {bs, 8'(e), mant};
  endfunction
endpackage

// File: rtl/mm_skew.sv
module mm_skew #(
  parameter int W = 16,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         vld_i,
  output logic [W-1:0] d_o,
  output logic         vld_o
);
  if (D == 0) begin : g_pass
    assign d_o   = d_i;
    assign vld_o = vld_i;
  end else begin : g_pipe
    logic [W:0] pipe_q [D];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < D; s++) pipe_q[s] <= '0;
      end else begin
        pipe_q[0] <= {vld_i, d_i};
        for (int s = 1; s < D; s++) pipe_q[s] <= pipe_q[s-1];
      end
    end
    assign {vld_o, d_o} = pipe_q[D-1];
  end
endmodule

// File: rtl/mm_cell.sv
module mm_cell
  import mm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            shift_i,
  input  logic [BF_W-1:0] a_i,
  input  logic            a_vld_i,
  input  logic [BF_W-1:0] b_i,
  input  logic            b_vld_i,
  input  logic [FP_W-1:0] acc_below_i,
  output logic [BF_W-1:0] a_o,
  output logic            a_vld_o,
  output logic [BF_W-1:0] b_o,
  output logic            b_vld_o,
  output logic [FP_W-1:0] acc_o
);
  logic            mac_w;
  logic [FP_W-1:0] prod_w, base_w, sum_w;

  assign mac_w  = a_vld_i & b_vld_i & ~shift_i;
  assign prod_w = bf_mul(a_i, b_i);
  assign base_w = clr_i ? '0 : acc_o;
  assign sum_w  = f32_add(base_w, prod_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o     <= '0;
      b_o     <= '0;
      a_vld_o <= 1'b0;
      b_vld_o <= 1'b0;
    end else begin
      a_o     <= a_i;
      b_o     <= b_i;
      a_vld_o <= a_vld_i;
      b_vld_o <= b_vld_i;
    end
  end

  // drain shift beats clear, clear beats hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (shift_i) acc_o <= acc_below_i;
    else if (mac_w)   acc_o <= sum_w;
    else if (clr_i)   acc_o <= '0;
  end

  assert_meet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_vld_i == b_vld_i);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_vld_i && !clr_i && !shift_i) |=> $stable(acc_o));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !a_vld_i && !shift_i) |=> acc_o == '0);
  assert_nan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_w && a_i[14:7] == 8'hff && a_i[6:0] != 7'd0) |=> acc_o == F32_QNAN);
endmodule

// File: rtl/mm_systolic.sv
module mm_systolic
  import mm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              in_vld_i,
  input  logic [N*BF_W-1:0] a_col_i,
  input  logic [N*BF_W-1:0] b_row_i,
  input  logic              drain_i,
  output logic              out_vld_o,
  output logic [N*FP_W-1:0] out_row_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [BF_W-1:0] a_h  [N][N+1];
  logic            av_h [N][N+1];
  logic [BF_W-1:0] b_v  [N+1][N];
  logic            bv_v [N+1][N];
  logic [FP_W-1:0] acc_w   [N][N];
  logic [FP_W-1:0] below_w [N][N];

  logic          draining_q;
  logic [CW-1:0] row_q;

  for (genvar gi = 0; gi < N; gi++) begin : g_askew
    mm_skew #(.W(BF_W), .D(gi)) u_skew (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (a_col_i[gi*BF_W +: BF_W]),
      .vld_i (in_vld_i),
      .d_o   (a_h[gi][0]),
      .vld_o (av_h[gi][0])
    );
  end

  for (genvar gj = 0; gj < N; gj++) begin : g_bskew
    mm_skew #(.W(BF_W), .D(gj)) u_skew (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (b_row_i[gj*BF_W +: BF_W]),
      .vld_i (in_vld_i),
      .d_o   (b_v[0][gj]),
      .vld_o (bv_v[0][gj])
    );
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      if (gi == N - 1) begin : g_bot
        assign below_w[gi][gj] = '0;
      end else begin : g_mid
        assign below_w[gi][gj] = acc_w[gi+1][gj];
      end
      mm_cell u_cell (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (clr_i),
        .shift_i    (draining_q),
        .a_i        (a_h[gi][gj]),
        .a_vld_i    (av_h[gi][gj]),
        .b_i        (b_v[gi][gj]),
        .b_vld_i    (bv_v[gi][gj]),
        .acc_below_i(below_w[gi][gj]),
        .a_o        (a_h[gi][gj+1]),
        .a_vld_o    (av_h[gi][gj+1]),
        .b_o        (b_v[gi+1][gj]),
        .b_vld_o    (bv_v[gi+1][gj]),
        .acc_o      (acc_w[gi][gj])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      draining_q <= 1'b0;
      row_q      <= '0;
    end else if (draining_q) begin
      row_q <= row_q + 1'b1;
      if (row_q == LAST) draining_q <= 1'b0;
    end else if (drain_i) begin
      draining_q <= 1'b1;
      row_q      <= '0;
    end
  end

  assign out_vld_o = draining_q;
  for (genvar gj = 0; gj < N; gj++) begin : g_out
    assign out_row_o[gj*FP_W +: FP_W] = acc_w[0][gj];
  end

  assert_drain_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_vld_o) |-> $past(drain_i));
  assert_drain_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && row_q == LAST) |=> (!out_vld_o && out_row_o == '0));
  assert_redrain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && drain_i && row_q != LAST) |=> (out_vld_o && row_q != '0));
endmodule

// File: tb/mm_systolic_tb.sv
module mm_systolic_tb;
  localparam int N = 4;
  localparam int KMAX = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            clr_i = 1'b0;
  logic            in_vld_i = 1'b0;
  logic [N*16-1:0] a_col_i = '0;
  logic [N*16-1:0] b_row_i = '0;
  logic            drain_i = 1'b0;
  logic            out_vld_o;
  logic [N*32-1:0] out_row_o;

  always #4 clk_i = ~clk_i;

  mm_systolic #(.N(N)) u_dut (.*);

  int nvec = 0;
  int nerr = 0;
  string cur_tag = "R10";
  int unsigned seed = 32'h1234_5678;

  logic [15:0] ta [N][KMAX];
  logic [15:0] tb [KMAX][N];
  logic [31:0] mc   [N][N];
  logic [31:0] snap [N][N];
  bit m_drain = 0;
  int m_ptr = 0;

  function automatic real f2r(input logic [31:0] x);
    logic [63:0] d;
    if (x[30:23] == 8'h00) return 0.0;
    d = {x[31], 11'(int'(x[30:23]) - 127 + 1023), x[22:0], 29'd0};
    return $bitstoreal(d);
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic [63:0] d;
    logic [24:0] m;
    logic [28:0] rem;
    int e;
    d = $realtobits(r);
    if (d[62:0] == 63'd0) return '0;
    e = int'(d[62:52]) - 1023 + 127;
    m = {2'b01, d[51:29]};
    rem = d[28:0];
    if (rem > 29'h1000_0000 || (rem == 29'h1000_0000 && m[0])) m = m + 25'd1;
    if (m[24]) begin
      m = 25'h080_0000;
      e = e + 1;
    end
    if (e >= 255) return {d[63], 8'hff, 23'd0};
    if (e <= 0) return '0;
    return {d[63], 8'(e), m[22:0]};
  endfunction

  function automatic bit is_nan(input logic [31:0] x);
    return x[30:23] == 8'hff && x[22:0] != 0;
  endfunction
  function automatic bit is_inf(input logic [31:0] x);
    return x[30:23] == 8'hff && x[22:0] == 0;
  endfunction
  function automatic bit is_zero(input logic [31:0] x);
    return x[30:23] == 8'h00;
  endfunction

  function automatic logic [31:0] m_mul(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] x, y;
    x = {a, 16'd0};
    y = {b, 16'd0};
    if (is_nan(x) || is_nan(y)) return 32'h7fc0_0000;
    if ((is_inf(x) && is_zero(y)) || (is_inf(y) && is_zero(x))) return 32'h7fc0_0000;
    if (is_inf(x) || is_inf(y)) return {x[31] ^ y[31], 8'hff, 23'd0};
    if (is_zero(x) || is_zero(y)) return '0;
    return r2f(f2r(x) * f2r(y));
  endfunction

  function automatic logic [31:0] m_add(input logic [31:0] x, input logic [31:0] y);
    if (is_nan(x) || is_nan(y)) return 32'h7fc0_0000;
    if (is_inf(x) && is_inf(y) && x[31] != y[31]) return 32'h7fc0_0000;
    if (is_inf(x)) return x;
    if (is_inf(y)) return y;
    return r2f(f2r(x) + f2r(y));
  endfunction

  function automatic logic [15:0] rnd_bf();
    logic [31:0] r;
    seed = seed * 32'd1664525 + 32'd1013904223;
    r = seed;
    return {r[31], 8'(124 + int'(r[20:0] % 7)), r[6:0]};
  endfunction

  // sample and compare after every edge
  task automatic cyc();
    bit req;
    req = drain_i;
    @(posedge clk_i);
    #2;
    if (m_drain) begin
      m_ptr++;
      if (m_ptr == N) m_drain = 0;
    end else if (req) begin
      m_drain = 1;
      m_ptr = 0;
    end
    nvec++;
    if (out_vld_o !== m_drain) begin
      nerr++;
      $display("FAIL R6 out_vld_o: got %b exp %b", out_vld_o, m_drain);
    end
    if (m_drain) begin
      for (int j = 0; j < N; j++) begin
        if (out_row_o[j*32 +: 32] !== snap[m_ptr][j]) begin
          nerr++;
          $display("FAIL %s row %0d col %0d: got %h exp %h", cur_tag, m_ptr, j,
                   out_row_o[j*32 +: 32], snap[m_ptr][j]);
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      in_vld_i = 0;
      clr_i = 0;
      drain_i = 0;
      cyc();
    end
  endtask

  task automatic do_drain(input int len);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        snap[i][j] = mc[i][j];
        mc[i][j] = '0;
      end
    for (int c = 0; c < len; c++) begin
      in_vld_i = 0;
      clr_i = 0;
      drain_i = 1;
      cyc();
    end
    idle(N + 1);
  endtask

  task automatic gen_rand(input int k);
    for (int i = 0; i < N; i++)
      for (int kk = 0; kk < k; kk++) ta[i][kk] = rnd_bf();
    for (int kk = 0; kk < k; kk++)
      for (int j = 0; j < N; j++) tb[kk][j] = rnd_bf();
  endtask

  task automatic run_tile(input int k, input bit clr_first, input bit gaps, input int drain_len);
    for (int kk = 0; kk < k; kk++) begin
      if (kk == 0 && clr_first)
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) mc[i][j] = '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) mc[i][j] = m_add(mc[i][j], m_mul(ta[i][kk], tb[kk][j]));
      for (int i = 0; i < N; i++) a_col_i[i*16 +: 16] = ta[i][kk];
      for (int j = 0; j < N; j++) b_row_i[j*16 +: 16] = tb[kk][j];
      in_vld_i = 1;
      clr_i = (kk == 0) && clr_first;
      drain_i = 0;
      cyc();
      if (gaps && kk == 1) idle(1);
    end
    idle(2 * N - 2);
    if (drain_len > 0) do_drain(drain_len);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nerr++;
    $display("FAIL R3 watchdog: got timeout exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mc[i][j] = '0;
        snap[i][j] = '0;
      end
    repeat (3) @(posedge clk_i);
    #2;
    nvec++;
    if (out_vld_o !== 1'b0 || out_row_o !== '0) begin
      nerr++;
      $display("FAIL R10 reset: got vld %b row %h exp 0", out_vld_o, out_row_o);
    end
    rst_ni = 1;
    idle(2);

    cur_tag = "R1";  gen_rand(1); run_tile(1, 1, 0, 1);
    cur_tag = "R2";  gen_rand(8); run_tile(8, 1, 0, 1);
    cur_tag = "R3";  gen_rand(3); run_tile(3, 1, 0, 1);
    cur_tag = "R3";  gen_rand(KMAX); run_tile(KMAX, 1, 0, 1);
    // gaps, then continuation without clear
    cur_tag = "R5";  gen_rand(5); run_tile(5, 1, 1, 0);
    gen_rand(3); run_tile(3, 0, 0, 1);
    // clear with first beat over stale sums
    cur_tag = "R4";  gen_rand(4); run_tile(4, 1, 0, 0);
    gen_rand(2); run_tile(2, 1, 0, 1);
    // clear on an idle cycle
    gen_rand(3); run_tile(3, 1, 0, 0);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) mc[i][j] = '0;
    in_vld_i = 0; clr_i = 1; drain_i = 0; cyc();
    gen_rand(2); run_tile(2, 0, 0, 1);
    // drain request held during a drain
    cur_tag = "R7";  gen_rand(2); run_tile(2, 1, 0, 3);
    // drain leaves zeros behind
    cur_tag = "R6";  do_drain(1);
    // NaN, inf*0, overflow, underflow
    cur_tag = "R8";
    ta[0][0] = 16'h7fc1; ta[1][0] = 16'h7f80; ta[2][0] = 16'h7f00; ta[3][0] = 16'h0080;
    tb[0][0] = 16'h3f80; tb[0][1] = 16'h0000; tb[0][2] = 16'h7f00; tb[0][3] = 16'h3e80;
    run_tile(1, 1, 0, 1);
    // cancellation, inf - inf, denormal input, signed overflow
    cur_tag = "R9";
    ta[0][0] = 16'h4040; ta[0][1] = 16'h4040;
    ta[1][0] = 16'h7f80; ta[1][1] = 16'h7f80;
    ta[2][0] = 16'h0005; ta[2][1] = 16'h3f80;
    ta[3][0] = 16'hff00; ta[3][1] = 16'h3f80;
    tb[0][0] = 16'h3fc0; tb[0][1] = 16'h3f80; tb[0][2] = 16'h7f00; tb[0][3] = 16'h4000;
    tb[1][0] = 16'hbfc0; tb[1][1] = 16'hbf80; tb[1][2] = 16'h3f80; tb[1][3] = 16'h0000;
    run_tile(2, 1, 0, 1);
    cur_tag = "R2";  gen_rand(12); run_tile(12, 1, 1, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule